// File: doc/BRIEF.md
# Light Sample Result Word Packer

This block sits behind the converter of a two-channel light sensor. Each time a conversion finishes it takes the result as a 4-bit exponent and a 20-bit mantissa, together with the index of the channel that produced it. It then builds two 16-bit words for that channel, ready for a register read path. Each channel keeps a private 4-bit sample counter that wraps, so a reader can tell a new sample from an old one.

Four check bits go along with each sample. They are sparse XOR parity equations over the exponent, the mantissa and the stored counter value, not a polynomial CRC. A reader recomputes them from the two words to detect a torn or corrupted read. Only the strobed channel's counter and words change, and the words stay fixed between strobes.

Top module: `rwp_result_packer`

## Requirements
- R1: After a synchronous active-low reset, both words of every channel read 0x0000, and every sample counter is zero.
- R2: The high word of a channel holds the exponent in bits 15:12 and mantissa bits 19:8 in bits 11:0, from the most recent conversion on that channel.
- R3: The low word of a channel holds mantissa bits 7:0 in bits 15:8.
- R4: The low word holds the channel's sample counter in bits 7:4. The counter goes up by one on every conversion of that channel and wraps from 15 to 0.
- R5: The counter stored with a sample is the value after its increment, so the first conversion after reset shows 1.
- R6: Low-word bit 0 is the XOR of all 4 exponent bits, all 20 mantissa bits and all 4 stored counter bits.
- R7: Low-word bit 1 is the XOR of counter bits 1 and 3, the odd mantissa bits (1, 3, ..., 19) and exponent bits 1 and 3.
- R8: Low-word bit 2 is the XOR of counter bit 3, mantissa bits 3, 7, 11, 15 and 19, and exponent bit 3.
- R9: Low-word bit 3 is the XOR of mantissa bits 3, 11 and 19.
- R10: A conversion strobe on one channel leaves the other channel's words and counter unchanged.
- R11: While the conversion-done strobe is low, every word holds its value whatever the other inputs do.
- R12: The words change at the first rising clock edge that samples the strobe high, and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| done_i | input | 1 | Conversion finished, one sample per high cycle |
| ch_i | input | 1 | Channel index of the finished conversion |
| exp_i | input | 4 | Exponent of the result |
| mant_i | input | 20 | Mantissa of the result |
| word_a_o | output | 32 | High words, channel k at bits 16k+15:16k |
| word_b_o | output | 32 | Low words, channel k at bits 16k+15:16k |

## Verification
The assertions assume that the strobe, channel index and result are stable and free of X at each rising edge once reset is released. They also assume that one channel index is given per strobe. The bench drives every input on the falling edge, so each value is settled at the next rising edge. It sends strobes singly, back to back and alternating between channels, and it changes the exponent and mantissa while the strobe is low, to show that those values are not taken in.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
    // Field widths of one packed sample
    localparam int EXP_W     = 4;
    localparam int MANT_W    = 20;
    localparam int CNT_W     = 4;
    localparam int CHK_W     = 4;
    localparam int WORD_W    = 16;
    // Split of the mantissa between the two words
    localparam int MANT_HI_W = WORD_W - EXP_W;
    localparam int MANT_LO_W = MANT_W - MANT_HI_W;

    typedef struct packed {
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
    } conv_t;
endpackage

// File: rtl/rwp_check_gen.sv
// Check-bit generator.
// Purely combinational. It forms four sparse XOR parity bits over the exponent,
// the mantissa and a counter value. It assumes the field widths of rwp_pkg.
module rwp_check_gen
    import rwp_pkg::*;
(
    input  logic [EXP_W-1:0]  expo_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CHK_W-1:0]  chk_o
);
    logic odd_mant;
    logic quad_mant;

    // Strided mantissa parities: every odd bit, and every fourth bit from bit 3
    always_comb begin
        odd_mant  = 1'b0;
        quad_mant = 1'b0;
        for (int i = 1; i < MANT_W; i += 2) odd_mant  ^= mant_i[i];
        for (int i = 3; i < MANT_W; i += 4) quad_mant ^= mant_i[i];
    end

    // Combine the strided parities with the exponent and counter terms
    always_comb begin
        chk_o[0] = ^{expo_i, mant_i, cnt_i};
        chk_o[1] = cnt_i[1] ^ cnt_i[3] ^ odd_mant ^ expo_i[1] ^ expo_i[3];
        chk_o[2] = cnt_i[3] ^ quad_mant ^ expo_i[3];
        chk_o[3] = mant_i[3] ^ mant_i[11] ^ mant_i[19];
    end
endmodule

// File: rtl/rwp_strobe_decode.sv
// Strobe decoder.
// It turns the shared done strobe and the channel index into one load enable
// per channel. An index of NUM_CH or more loads no channel.
module rwp_strobe_decode #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic              done_i,
    input  logic [CH_W-1:0]   ch_i,
    output logic [NUM_CH-1:0] load_o
);
    // One-hot load for the addressed channel
    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            load_o[k] = done_i && (int'(ch_i) == k);
        end
    end
endmodule

// File: rtl/rwp_channel_slot.sv
// Per-channel state.
// It holds the rolling sample counter and the two packed words. Both update
// only on load_i. The check bits cover the counter value after the increment.
module rwp_channel_slot
    import rwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  conv_t             conv_i,
    output logic [WORD_W-1:0] word_a_o,
    output logic [WORD_W-1:0] word_b_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CHK_W-1:0] chk;

    // Next counter value, wrapping naturally at its width
    always_comb cnt_nxt = cnt_q + CNT_W'(1);

    rwp_check_gen u_chk (
        .expo_i (conv_i.expo),
        .mant_i (conv_i.mant),
        .cnt_i  (cnt_nxt),
        .chk_o  (chk)
    );

    // Register the counter and both words on a load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            word_a_o <= '0;
            word_b_o <= '0;
        end else if (load_i) begin
            cnt_q    <= cnt_nxt;
            word_a_o <= {conv_i.expo, conv_i.mant[MANT_W-1 -: MANT_HI_W]};
            word_b_o <= {conv_i.mant[MANT_LO_W-1:0], cnt_nxt, chk};
        end
    end
endmodule

// File: rtl/rwp_result_packer.sv
// Result word packer, top level.
// It routes each finished conversion to its channel slot and flattens the
// words onto the output buses. The inputs are assumed stable around the clock edge.
module rwp_result_packer
    import rwp_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     done_i,
    input  logic [CH_W-1:0]          ch_i,
    input  logic [EXP_W-1:0]         exp_i,
    input  logic [MANT_W-1:0]        mant_i,
    output logic [NUM_CH*WORD_W-1:0] word_a_o,
    output logic [NUM_CH*WORD_W-1:0] word_b_o
);
    logic [NUM_CH-1:0] load;
    conv_t             conv;

    // Bundle the raw result fields
    always_comb conv = '{expo: exp_i, mant: mant_i};

    rwp_strobe_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
        .done_i (done_i),
        .ch_i   (ch_i),
        .load_o (load)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        rwp_channel_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load[k]),
            .conv_i   (conv),
            .word_a_o (word_a_o[k*WORD_W +: WORD_W]),
            .word_b_o (word_b_o[k*WORD_W +: WORD_W])
        );
    end
endmodule

// File: rtl/rwp_result_packer_chk.sv
// Assertion checker for rwp_result_packer. It is attached with bind and
// observes the ports only.
module rwp_result_packer_chk
    import rwp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     done_i,
    input logic [CH_W-1:0]          ch_i,
    input logic [EXP_W-1:0]         exp_i,
    input logic [MANT_W-1:0]        mant_i,
    input logic [NUM_CH*WORD_W-1:0] word_a_o,
    input logic [NUM_CH*WORD_W-1:0] word_b_o
);
    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> ($stable(word_a_o) && $stable(word_b_o)));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_c
        // R2 R12
        word_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i && int'(ch_i) == k) |=>
            word_a_o[k*WORD_W +: WORD_W] == {$past(exp_i), $past(mant_i[19:8])});
        // R4
        count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i && int'(ch_i) == k) |=>
            word_b_o[k*WORD_W+4 +: 4] == $past(word_b_o[k*WORD_W+4 +: 4]) + 4'd1);
        // R10
        other_ch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i && int'(ch_i) != k) |=>
            ($stable(word_a_o[k*WORD_W +: WORD_W]) && $stable(word_b_o[k*WORD_W +: WORD_W])));
        // R9
        chk3_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            word_b_o[k*WORD_W+3] ==
            (word_b_o[k*WORD_W+11] ^ word_a_o[k*WORD_W+3] ^ word_a_o[k*WORD_W+11]));
        // R8
        chk2_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            word_b_o[k*WORD_W+2] ==
            (word_b_o[k*WORD_W+7] ^ word_b_o[k*WORD_W+11] ^ word_b_o[k*WORD_W+15] ^
             word_a_o[k*WORD_W+3] ^ word_a_o[k*WORD_W+7] ^ word_a_o[k*WORD_W+11] ^
             word_a_o[k*WORD_W+15]));
    end
endmodule

bind rwp_result_packer rwp_result_packer_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_i   (done_i),
    .ch_i     (ch_i),
    .exp_i    (exp_i),
    .mant_i   (mant_i),
    .word_a_o (word_a_o),
    .word_b_o (word_b_o)
);

// File: tb/rwp_result_packer_tb.sv
`timescale 1ns/1ps
module rwp_result_packer_tb;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done = 1'b0;
    logic [0:0]  ch = '0;
    logic [3:0]  ex = '0;
    logic [19:0] ma = '0;
    logic [31:0] wa, wb;

    int errs = 0;
    int checks = 0;

    // Behavioural reference state
    int          m_cnt [NCH] = '{0, 0};
    logic [3:0]  m_e   [NCH] = '{4'h0, 4'h0};
    logic [19:0] m_m   [NCH] = '{20'h0, 20'h0};

    always #2.5 clk = ~clk;

    rwp_result_packer u_dut (
        .clk(clk), .rst_n(rst_n), .done_i(done), .ch_i(ch),
        .exp_i(ex), .mant_i(ma), .word_a_o(wa), .word_b_o(wb)
    );

    function automatic logic [3:0] ref_chk(logic [3:0] e, logic [19:0] m, logic [3:0] c);
        logic [3:0] x = '0;
        for (int i = 0; i < 4; i++)  x[0] ^= e[i] ^ c[i];
        for (int i = 0; i < 20; i++) x[0] ^= m[i];
        x[1] = c[1] ^ c[3] ^ e[1] ^ e[3];
        for (int i = 1; i < 20; i += 2) x[1] ^= m[i];
        x[2] = c[3] ^ e[3];
        for (int i = 3; i < 20; i += 4) x[2] ^= m[i];
        x[3] = m[3] ^ m[11] ^ m[19];
        return x;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference update at each edge, then compare shortly after
    always @(posedge clk) begin
        logic [3:0] c;
        logic [3:0] x;
        if (!rst_n) begin
            for (int k = 0; k < NCH; k++) begin
                m_cnt[k] = 0; m_e[k] = '0; m_m[k] = '0;
            end
        end else if (done) begin
            m_cnt[ch] = (m_cnt[ch] + 1) % 16;
            m_e[ch] = ex;
            m_m[ch] = ma;
        end
        #1;
        for (int k = 0; k < NCH; k++) begin
            c = 4'(m_cnt[k]);
            x = ref_chk(m_e[k], m_m[k], c);
            check("R2 R12 word A", wa[k*16 +: 16], {m_e[k], m_m[k][19:8]});
            check("R3 word B mantissa", {8'h0, wb[k*16+8 +: 8]}, {8'h0, m_m[k][7:0]});
            check("R4 counter", {12'h0, wb[k*16+4 +: 4]}, {12'h0, c});
            check("R6 check bit 0", {15'h0, wb[k*16+0]}, {15'h0, x[0]});
            check("R7 check bit 1", {15'h0, wb[k*16+1]}, {15'h0, x[1]});
            check("R8 check bit 2", {15'h0, wb[k*16+2]}, {15'h0, x[2]});
            check("R9 check bit 3", {15'h0, wb[k*16+3]}, {15'h0, x[3]});
        end
    end

    task automatic conv(int c, logic [3:0] e, logic [19:0] m);
        @(negedge clk);
        done = 1'b1; ch = 1'(c); ex = e; ma = m;
        @(negedge clk);
        done = 1'b0;
    endtask

    initial begin
        #1000000;
        errs++; checks++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [15:0] sa, sb;
        repeat (3) @(negedge clk);
        check("R1 reset word A", wa[15:0] | wa[31:16], 16'h0);
        check("R1 reset word B", wb[15:0] | wb[31:16], 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        conv(0, 4'hF, 20'hFFFFF);
        check("R5 first counter", {12'h0, wb[7:4]}, 16'h1);
        conv(0, 4'h0, 20'h00008);
        conv(0, 4'hA, 20'hAAAAA);
        conv(0, 4'h5, 20'h55555);
        conv(0, 4'h8, 20'h80808);

        // R10: channel 1 must not move while channel 0 is strobed
        conv(1, 4'h3, 20'h12345);
        sa = wa[31:16]; sb = wb[31:16];
        for (int i = 0; i < 11; i++) conv(0, 4'(i), 20'(i * 20'h1111));
        check("R10 ch1 word A held", wa[31:16], sa);
        check("R10 ch1 word B held", wb[31:16], sb);
        check("R4 wrap to zero", {12'h0, wb[7:4]}, 16'h0);

        // R11: inputs move but the strobe stays low
        sa = wa[15:0]; sb = wb[15:0];
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ex = 4'(i + 7); ma = 20'($urandom); ch = 1'(i);
        end
        check("R11 word A held", wa[15:0], sa);
        check("R11 word B held", wb[15:0], sb);

        // Back-to-back strobes, alternating channels
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            done = 1'b1; ch = 1'(i); ex = 4'($urandom); ma = 20'($urandom);
            @(negedge clk);
        end
        done = 1'b0;
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule